// File: doc/BRIEF.md
# Packed SIMD Add, Logic and Compare Unit

This unit performs one 64-bit packed integer operation per accepted input. The two operands are split into equal lanes (eight 8-bit, four 16-bit, two 32-bit or one 64-bit), and the unit works on each lane separately. It supports the following operations:

- add and subtract that wrap around within each lane;
- add and subtract that saturate, with signed or unsigned bounds;
- the four bitwise operations;
- equality and signed greater-than compares, which write a mask of all ones or all zeros into each lane.

A caller raises `in_valid` with an opcode, a lane size and the two operands. The registered result appears one clock later, marked by `out_valid`. The unit has no flags, and overflow is never reported. It runs as a fixed one-stage pipeline with no stall. Its only state is the output register: `out_valid` shows whether that register was loaded on the last edge, so the unit is either idle or presenting a result.

Opcode encoding on `op`:

| Code | Operation | Code | Operation |
|---|---|---|---|
| 0 | wrap add | 6 | and |
| 1 | wrap subtract | 7 | or |
| 2 | signed saturating add | 8 | xor |
| 3 | signed saturating subtract | 9 | and-not |
| 4 | unsigned saturating add | 10 | equality compare |
| 5 | unsigned saturating subtract | 11 | signed greater-than compare |

Lane size encoding on `lsize`: 0 selects 8-bit lanes, 1 selects 16-bit, 2 selects 32-bit and 3 selects 64-bit. Lane 0 always holds the least significant bits.

Top module: `pk_simd_unit`

## Requirements
- R1: After reset, `out_valid` and `result` are 0. `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` keeps its value while `in_valid` is low. An asynchronous reset clears both at once.
- R2: Ops 0 and 1 with `lsize` 0, 1 or 2 give a per-lane sum or difference modulo 2^lane width. A carry or borrow never reaches the neighbouring lane.
- R3: Ops 2 and 3 with `lsize` 0 or 1 clamp signed results. Byte lanes clamp to 0x7F or 0x80, and 16-bit lanes clamp to 0x7FFF or 0x8000. Results in range pass through unchanged.
- R4: Op 4 with `lsize` 0 or 1 clamps each lane sum above the unsigned maximum to all ones.
- R5: Op 5 with `lsize` 0 or 1 clamps each lane difference below zero to 0.
- R6: Ops 6, 7 and 8 give the bitwise AND, OR and XOR of all 64 bits, for any `lsize`.
- R7: Op 9 gives the complement of `src_a` ANDed with `src_b`, for any `lsize`.
- R8: Op 10 with `lsize` 0, 1 or 2 writes all ones into each lane whose operands are equal and zeros into every other lane.
- R9: Op 11 with `lsize` 0, 1 or 2 writes all ones into each lane where `src_a` is greater than `src_b` as signed numbers, and zeros into every other lane.
- R10: Each of the following gives a result of 0:
  - ops 12 to 15;
  - saturating ops with `lsize` 2 or 3;
  - arithmetic or compare ops with `lsize` 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation request this cycle |
| op | input | 4 | Opcode, encoded as in the table above |
| lsize | input | 2 | Lane size: 0 byte, 1 16-bit, 2 32-bit, 3 64-bit |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| out_valid | output | 1 | Result register loaded on the last edge |
| result | output | 64 | Registered result |

## Verification
The arithmetic vectors pair all-ones operands with small addends at byte, 16-bit and 32-bit lane sizes. A carry leaking between lanes would turn the expected zero result into a visibly different value.

The saturating vectors put the following cases in the same operand pair:
- lanes that clamp at the upper bound;
- lanes that clamp at the lower bound;
- lanes that just reach a bound without clamping;
- lanes that stay inside the range.

This separates a wrong threshold from a wrong clamp value.

The compare vectors use alternating true and false lanes, including equal operands for greater-than and sign-crossing pairs. This exposes lane misalignment and unsigned comparison. Directed tests cover the handshake timing, result hold, reset in mid-stream and the combinations that must give zero.

// File: rtl/pk_simd_pkg.sv
package pk_simd_pkg;

    typedef enum logic [3:0] {
        OP_ADD_WRAP  = 4'd0,
        OP_SUB_WRAP  = 4'd1,
        OP_ADD_SSAT  = 4'd2,
        OP_SUB_SSAT  = 4'd3,
        OP_ADD_USAT  = 4'd4,
        OP_SUB_USAT  = 4'd5,
        OP_AND       = 4'd6,
        OP_OR        = 4'd7,
        OP_XOR       = 4'd8,
        OP_ANDN      = 4'd9,
        OP_CMPEQ     = 4'd10,
        OP_CMPGT     = 4'd11
    } op_e;

    typedef enum logic [1:0] {
        LSZ_BYTE  = 2'd0,
        LSZ_WORD  = 2'd1,
        LSZ_DWORD = 2'd2,
        LSZ_QUAD  = 2'd3
    } lsz_e;

    typedef enum logic [1:0] {
        SAT_NONE     = 2'd0,
        SAT_SIGNED   = 2'd1,
        SAT_UNSIGNED = 2'd2
    } sat_e;

    typedef enum logic [2:0] {
        CLS_ZERO  = 3'd0,
        CLS_ARITH = 3'd1,
        CLS_LOGIC = 3'd2,
        CLS_EQ    = 3'd3,
        CLS_GT    = 3'd4
    } cls_e;

endpackage

// File: rtl/simd_lane_addsub.sv
module simd_lane_addsub
    import pk_simd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  sat_e         sat,
    output logic [W-1:0] y
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] UMAX = {W{1'b1}};

    logic [W-1:0] b_eff;
    logic [W:0]   sum;
    logic [W-1:0] raw;
    logic         s_ovf;
    logic         u_out;

    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        raw   = sum[W-1:0];
        // signed overflow: like-signed inputs giving a result of the other sign
        s_ovf = (a[W-1] == b_eff[W-1]) && (raw[W-1] != a[W-1]);
        // unsigned: carry out for add, missing carry (borrow) for subtract
        u_out = sub ? ~sum[W] : sum[W];
        unique case (sat)
            SAT_SIGNED:   y = s_ovf ? (a[W-1] ? SMIN : SMAX) : raw;
            SAT_UNSIGNED: y = u_out ? (sub ? '0 : UMAX) : raw;
            default:      y = raw;
        endcase
    end

    always_comb begin
        if (sat == SAT_UNSIGNED && !sub) begin
            a_r4_uadd_not_below: assert (y >= a);
        end
        if (sat == SAT_UNSIGNED && sub) begin
            a_r5_usub_not_above: assert (y <= a);
        end
    end

endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] eq_mask,
    output logic [W-1:0] gt_mask
);
    logic is_eq;
    logic is_gt;

    always_comb begin
        is_eq   = (a == b);
        is_gt   = ($signed(a) > $signed(b));
        eq_mask = {W{is_eq}};
        gt_mask = {W{is_gt}};
    end

    always_comb begin
        a_r9_gt_excludes_eq: assert (!(is_eq && is_gt));
    end

endmodule

// File: rtl/simd_bitwise.sv
module simd_bitwise
    import pk_simd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_ANDN: y = ~a & b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/pk_simd_unit.sv
module pk_simd_unit
    import pk_simd_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int MIN_LANE_W = 8,
    parameter int N_SIZES    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic [1:0]        lsize,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    localparam int SZ_W = $clog2(N_SIZES + 1);

    // per-size lane results, index = lane-size code
    logic [N_SIZES-1:0][DATA_W-1:0] as_v;
    logic [N_SIZES-1:0][DATA_W-1:0] eq_v;
    logic [N_SIZES-1:0][DATA_W-1:0] gt_v;
    logic [DATA_W-1:0]              logic_v;

    logic              is_sub;
    sat_e              sat_mode;
    cls_e              cls;
    logic              combo_ok;
    logic [DATA_W-1:0] nxt;
    logic              out_valid_q;
    logic [DATA_W-1:0] result_q;

    // ---------------- decode ----------------
    always_comb begin
        is_sub   = 1'b0;
        sat_mode = SAT_NONE;
        cls      = CLS_ZERO;
        unique case (op_e'(op))
            OP_ADD_WRAP: cls = CLS_ARITH;
            OP_SUB_WRAP: begin cls = CLS_ARITH; is_sub = 1'b1; end
            OP_ADD_SSAT: begin cls = CLS_ARITH; sat_mode = SAT_SIGNED; end
            OP_SUB_SSAT: begin cls = CLS_ARITH; sat_mode = SAT_SIGNED; is_sub = 1'b1; end
            OP_ADD_USAT: begin cls = CLS_ARITH; sat_mode = SAT_UNSIGNED; end
            OP_SUB_USAT: begin cls = CLS_ARITH; sat_mode = SAT_UNSIGNED; is_sub = 1'b1; end
            OP_AND, OP_OR, OP_XOR, OP_ANDN: cls = CLS_LOGIC;
            OP_CMPEQ:    cls = CLS_EQ;
            OP_CMPGT:    cls = CLS_GT;
            default:     cls = CLS_ZERO;
        endcase
    end

    // lane-size / opcode combinations that are defined
    always_comb begin
        combo_ok = 1'b1;
        if (cls != CLS_LOGIC && {{(SZ_W > 2 ? SZ_W-2 : 0){1'b0}}, lsize} >= SZ_W'(N_SIZES))
            combo_ok = 1'b0;
        if (sat_mode != SAT_NONE && lsize >= 2'(LSZ_DWORD))
            combo_ok = 1'b0;
    end

    // ---------------- lane datapath ----------------
    for (genvar g = 0; g < N_SIZES; g++) begin : g_size
        localparam int LW = MIN_LANE_W << g;
        localparam int NL = DATA_W / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            simd_lane_addsub #(.W(LW)) u_as (
                .a   (src_a[l*LW +: LW]),
                .b   (src_b[l*LW +: LW]),
                .sub (is_sub),
                .sat (sat_mode),
                .y   (as_v[g][l*LW +: LW])
            );
            simd_lane_cmp #(.W(LW)) u_cmp (
                .a       (src_a[l*LW +: LW]),
                .b       (src_b[l*LW +: LW]),
                .eq_mask (eq_v[g][l*LW +: LW]),
                .gt_mask (gt_v[g][l*LW +: LW])
            );
        end
    end

    simd_bitwise #(.DATA_W(DATA_W)) u_bit (
        .op (op_e'(op)),
        .a  (src_a),
        .b  (src_b),
        .y  (logic_v)
    );

    // ---------------- result select ----------------
    always_comb begin
        nxt = '0;
        if (combo_ok) begin
            unique case (cls)
                CLS_LOGIC: nxt = logic_v;
                CLS_ARITH, CLS_EQ, CLS_GT: begin
                    for (int s = 0; s < N_SIZES; s++) begin
                        if (int'(lsize) == s) begin
                            if (cls == CLS_ARITH)   nxt = as_v[s];
                            else if (cls == CLS_EQ) nxt = eq_v[s];
                            else                    nxt = gt_v[s];
                        end
                    end
                end
                default: nxt = '0;
            endcase
        end
    end

    // ---------------- output register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
        end else begin
            out_valid_q <= in_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (in_valid) begin
            result_q <= nxt;
        end
    end

    assign out_valid = out_valid_q;
    assign result    = result_q;

    // ---------------- assertions ----------------
    a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    a_r7_andn_form: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op == 4'd9 |=> result == (~$past(src_a) & $past(src_b)));
    a_r8_eq_self: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op == 4'd10 && src_a == src_b && lsize != 2'd3 |=> &result);
    a_r10_bad_op_zero: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op >= 4'd12 |=> result == '0);

endmodule

// File: tb/sim_pk_simd_unit.sv
module sim_pk_simd_unit;

    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  sz;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        // R2 wrap add, lane carries dropped
        '{4'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 64'h0, 4'd2},
        '{4'd0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 64'h0, 4'd2},
        '{4'd0, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 64'h0, 4'd2},
        // R2 wrap subtract, borrows dropped
        '{4'd1, 2'd0, 64'h0, 64'h0101_0101_0101_0101, 64'hFFFF_FFFF_FFFF_FFFF, 4'd2},
        '{4'd1, 2'd2, 64'h0000_0005_0000_0003, 64'h0000_0002_0000_0004, 64'h0000_0003_FFFF_FFFF, 4'd2},
        // R3 signed saturation
        '{4'd2, 2'd0, 64'h7F80_01FF_7F80_1000, 64'h01FF_0101_7F80_F000, 64'h7F80_0200_7F80_0000, 4'd3},
        '{4'd3, 2'd1, 64'h8000_7FFF_0005_FFFF, 64'h0001_FFFF_0007_7FFF, 64'h8000_7FFF_FFFE_8000, 4'd3},
        // R4 unsigned saturating add
        '{4'd4, 2'd0, 64'hFF80_0100_F010_7FFE, 64'h0180_0100_0FF1_8001, 64'hFFFF_0200_FFFF_FFFF, 4'd4},
        '{4'd4, 2'd1, 64'hFFFF_1234_8000_0001, 64'h0001_1111_8000_0002, 64'hFFFF_2345_FFFF_0003, 4'd4},
        // R5 unsigned saturating subtract
        '{4'd5, 2'd0, 64'h0005_80FF_1001_007F, 64'h0103_81FF_2000_0080, 64'h0002_0000_0001_0000, 4'd5},
        '{4'd5, 2'd1, 64'h0005_8000_FFFF_0000, 64'h0006_7FFF_0001_0000, 64'h0000_0001_FFFE_0000, 4'd5},
        // R6 bitwise, lane size has no effect
        '{4'd6, 2'd3, 64'hF0F0_F0F0_0F0F_0F0F, 64'hFF00_FF00_FF00_FF00, 64'hF000_F000_0F00_0F00, 4'd6},
        '{4'd7, 2'd1, 64'hF0F0_F0F0_0F0F_0F0F, 64'hFF00_FF00_FF00_FF00, 64'hFFF0_FFF0_FF0F_FF0F, 4'd6},
        '{4'd8, 2'd2, 64'hF0F0_F0F0_0F0F_0F0F, 64'hFF00_FF00_FF00_FF00, 64'h0FF0_0FF0_F00F_F00F, 4'd6},
        // R7 and-not
        '{4'd9, 2'd0, 64'hF0F0_F0F0_0F0F_0F0F, 64'hFF00_FF00_FF00_FF00, 64'h0F00_0F00_F000_F000, 4'd7},
        // R8 equality masks
        '{4'd10, 2'd0, 64'h1122_3344_5566_7788, 64'h1100_3300_5500_7700, 64'hFF00_FF00_FF00_FF00, 4'd8},
        '{4'd10, 2'd1, 64'h0001_0002_0003_0004, 64'h0001_0102_0003_0004, 64'hFFFF_0000_FFFF_FFFF, 4'd8},
        '{4'd10, 2'd2, 64'h1234_5678_0000_0000, 64'h1234_5678_0000_0001, 64'hFFFF_FFFF_0000_0000, 4'd8},
        // R9 signed greater-than masks
        '{4'd11, 2'd0, 64'h0180_7FFF_0005_FF80, 64'h007F_8000_FF05_FE81, 64'hFF00_FF00_FF00_FF00, 4'd9},
        '{4'd11, 2'd1, 64'h8000_0001_FFFF_7FFF, 64'h7FFF_0000_FFFF_8000, 64'h0000_FFFF_0000_FFFF, 4'd9},
        '{4'd11, 2'd2, 64'h8000_0000_0000_0001, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 4'd9},
        // R10 undefined combinations give zero
        '{4'd2, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 4'd10},
        '{4'd5, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 4'd10},
        '{4'd0, 2'd3, 64'h1, 64'h1, 64'h0, 4'd10},
        '{4'd10, 2'd3, 64'h5, 64'h5, 64'h0, 4'd10},
        '{4'd15, 2'd0, 64'hFF, 64'hFF, 64'h0, 4'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  lsize = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pk_simd_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .lsize     (lsize),
        .src_a     (src_a),
        .src_b     (src_b),
        .out_valid (out_valid),
        .result    (result)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_valid = 1'b1;
        op       = v.op;
        lsize    = v.sz;
        src_a    = v.a;
        src_b    = v.b;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset out_valid", {63'b0, out_valid}, 64'h0);
        chk("R1 reset result", result, 64'h0);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            @(negedge clk);
            in_valid = 1'b0;
            chk($sformatf("R1 out_valid vec %0d", i), {63'b0, out_valid}, 64'h1);
            chk($sformatf("R%0d vec %0d", VEC[i].req, i), result, VEC[i].exp);
        end

        // R1: idle cycle drops out_valid, result held
        @(negedge clk);
        chk("R1 idle out_valid", {63'b0, out_valid}, 64'h0);
        chk("R1 idle hold", result, VEC[NV-1].exp);

        // R1 back-to-back; R3 then R7 with new operands while idle input changes
        @(negedge clk);
        drive(VEC[5]);
        @(negedge clk);
        chk("R3 stream first", result, VEC[5].exp);
        drive(VEC[14]);
        @(negedge clk);
        chk("R7 stream second", result, VEC[14].exp);
        chk("R1 stream valid", {63'b0, out_valid}, 64'h1);
        in_valid = 1'b0;
        op       = 4'd6;
        src_a    = '1;
        src_b    = '1;
        @(negedge clk);
        chk("R1 idle inputs ignored", result, VEC[14].exp);

        // R1 asynchronous reset mid-stream
        drive(VEC[7]);
        @(negedge clk);
        chk("R4 before reset", result, VEC[7].exp);
        #1 rst_n = 1'b0;
        #0.5;
        chk("R1 async reset result", result, 64'h0);
        chk("R1 async reset valid", {63'b0, out_valid}, 64'h0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset idle", {63'b0, out_valid}, 64'h0);

        finish_run();
    end

endmodule